// File: doc/BRIEF.md
# Addressed Serial Receiver with Station Filtering

This block receives asynchronous serial frames on one line that several stations share. Each station has its own 8-bit address. The line is sampled on a 16x oversampling tick, and the block checks every frame for a valid stop bit.

In addressed mode, each frame carries one extra flag bit after the eighth data bit. When the flag is 1, the frame is an address frame. When the flag is 0, the frame is a payload frame. The receiver throws away payload frames until an address frame carries its own station address. After that it passes payload frames to the host. The next address frame that carries a different address ends the selection. When addressed mode is off, the flag bit is not sent and every well-formed frame goes to the host.

The host sees one holding register with a ready flag, an overrun flag and a framing-error flag. A receive interrupt follows the ready flag and an error interrupt follows the framing-error flag. One clear input drops all three flags.

Top module: `mp_uart_rx`

## Requirements
- R1: After reset, rx_byte_o is 0 and rdy_o, overrun_o, frame_err_o, rx_irq_o and err_irq_o are all 0.
- R2: A frame is a 0 start bit, 8 data bits with the least significant bit first, and a 1 stop bit. Each bit lasts 16 pulses of tick_i. With mp_en_i low there is no flag bit, and every frame with a good stop bit is delivered to rx_byte_o.
- R3: A start bit is accepted only if the line is still 0 at the 8th tick sample after the falling edge. A low pulse shorter than that produces no frame and changes no output.
- R4: With mp_en_i high, one flag bit follows D7 and comes before the stop bit (1 = address frame, 0 = payload frame). While the station is not selected, payload frames leave every output unchanged.
- R5: An address frame whose byte equals station_id_i selects the station. That address byte is itself delivered, and the payload frames that follow are delivered too.
- R6: An address frame whose byte differs from station_id_i is never delivered, and it deselects the station, so the payload frames that follow are ignored.
- R7: A delivered frame sets rdy_o and places its byte on rx_byte_o. rx_irq_o is high exactly while rdy_o is high.
- R8: A stop bit sampled as 0 sets frame_err_o and raises err_irq_o. The frame is not delivered and the selection state does not change.
- R9: If a frame is delivered while rdy_o is still set, overrun_o is set and rx_byte_o keeps the unread byte.
- R10: A one-cycle pulse on flag_clr_i clears rdy_o, overrun_o and frame_err_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_i | input | 1 | Serial line, idles at 1 |
| tick_i | input | 1 | One-cycle pulse at 16 times the bit rate |
| station_id_i | input | 8 | This station's address |
| mp_en_i | input | 1 | Addressed mode enable |
| flag_clr_i | input | 1 | Clears the ready, overrun and framing-error flags |
| rx_byte_o | output | 8 | Last delivered byte |
| rdy_o | output | 1 | Unread byte present |
| overrun_o | output | 1 | A frame was delivered while rdy_o was set |
| frame_err_o | output | 1 | A stop bit was sampled as 0 |
| rx_irq_o | output | 1 | Receive interrupt request |
| err_irq_o | output | 1 | Error interrupt request |

## Verification
The hardest case to reach is a selected station that loses its selection. Reaching it takes a matching address frame, then payload frames, then a foreign address frame, and finally payload frames that must vanish, all with the host's clears placed in between. The random stream draws address bytes from the station's own address, a one-bit neighbour of it, and arbitrary values. It also mixes in bad stop bits and skipped clears. A reference model in the bench tracks the selection state so that it can predict every delivery, overrun and framing error.

// File: rtl/mp_uart_rx_pkg.sv
package mp_uart_rx_pkg;

    localparam int RX_DATA_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_FLAG,
        ST_STOP
    } rx_state_e;

    typedef struct packed {
        logic [RX_DATA_W-1:0] data;
        logic                 mp;    // frame received in addressed mode
        logic                 flag;  // address/payload flag bit
        logic                 ferr;  // stop bit sampled low
    } rx_frame_t;

    function automatic logic addr_hit(input logic [RX_DATA_W-1:0] a,
                                      input logic [RX_DATA_W-1:0] b);
        return a == b;
    endfunction

endpackage

// File: rtl/mpr_sampler.sv
module mpr_sampler
    import mp_uart_rx_pkg::*;
#(
    parameter int OVS         = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      rx_i,
    input  logic      tick_i,
    input  logic      mp_en_i,
    output logic      done_o,
    output rx_frame_t frame_o
);
    localparam int CNT_W = $clog2(OVS);
    localparam int BIT_W = $clog2(RX_DATA_W);
    localparam logic [CNT_W-1:0] CNT_MID  = CNT_W'(OVS / 2 - 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(OVS - 1);
    localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(RX_DATA_W - 1);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   rxs;

    generate
        if (SYNC_STAGES == 1) begin : g_sync1
            always_ff @(posedge clk) begin
                if (rst) sync_q <= '1;
                else     sync_q <= rx_i;
            end
        end else begin : g_syncn
            always_ff @(posedge clk) begin
                if (rst) sync_q <= '1;
                else     sync_q <= {sync_q[SYNC_STAGES-2:0], rx_i};
            end
        end
    endgenerate

    assign rxs = sync_q[SYNC_STAGES-1];

    rx_state_e              state_q;
    logic [CNT_W-1:0]       cnt_q;
    logic [BIT_W-1:0]       bit_q;
    logic [RX_DATA_W-1:0]   shift_q;
    logic                   flag_q;
    logic                   mp_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            bit_q   <= '0;
            shift_q <= '0;
            flag_q  <= 1'b0;
            mp_q    <= 1'b0;
            done_o  <= 1'b0;
            frame_o <= '0;
        end else begin
            done_o <= 1'b0;
            if (tick_i) begin
                case (state_q)
                    ST_IDLE: begin
                        if (!rxs) begin
                            state_q <= ST_START;
                            cnt_q   <= '0;
                        end
                    end
                    ST_START: begin
                        if (cnt_q == CNT_MID) begin
                            cnt_q <= '0;
                            bit_q <= '0;
                            state_q <= rxs ? ST_IDLE : ST_DATA;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                    ST_DATA: begin
                        if (cnt_q == CNT_LAST) begin
                            cnt_q   <= '0;
                            shift_q <= {rxs, shift_q[RX_DATA_W-1:1]};
                            if (bit_q == BIT_LAST) begin
                                mp_q    <= mp_en_i;
                                state_q <= mp_en_i ? ST_FLAG : ST_STOP;
                            end else begin
                                bit_q <= bit_q + 1'b1;
                            end
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                    ST_FLAG: begin
                        if (cnt_q == CNT_LAST) begin
                            cnt_q   <= '0;
                            flag_q  <= rxs;
                            state_q <= ST_STOP;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                    ST_STOP: begin
                        if (cnt_q == CNT_LAST) begin
                            cnt_q         <= '0;
                            frame_o.data  <= shift_q;
                            frame_o.mp    <= mp_q;
                            frame_o.flag  <= mp_q & flag_q;
                            frame_o.ferr  <= ~rxs;
                            done_o        <= 1'b1;
                            state_q       <= ST_IDLE;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                    default: state_q <= ST_IDLE;
                endcase
            end
        end
    end

    // R2: a completed frame is reported for exactly one cycle
    assert_done_single_R2: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    // R3: a start that is high again at its mid sample returns to idle
    assert_start_reject_R3: assert property (@(posedge clk) disable iff (rst)
        (tick_i && state_q == ST_START && cnt_q == CNT_MID && rxs) |=> !done_o);

endmodule

// File: rtl/mpr_filter.sv
module mpr_filter
    import mp_uart_rx_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 done_i,
    input  rx_frame_t            frame_i,
    input  logic [RX_DATA_W-1:0] station_id_i,
    output logic                 accept_o,
    output logic                 ferr_ev_o
);
    logic sel_q;
    logic hit;

    assign hit       = addr_hit(frame_i.data, station_id_i);
    assign ferr_ev_o = done_i & frame_i.ferr;

    always_comb begin
        accept_o = 1'b0;
        if (done_i && !frame_i.ferr) begin
            if (!frame_i.mp)       accept_o = 1'b1;
            else if (frame_i.flag) accept_o = hit;
            else                   accept_o = sel_q;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q <= 1'b0;
        end else if (done_i && !frame_i.ferr && frame_i.mp && frame_i.flag) begin
            sel_q <= hit;
        end
    end

    // R4: payload frames are dropped while unselected
    assert_unsel_drop_R4: assert property (@(posedge clk) disable iff (rst)
        (done_i && frame_i.mp && !frame_i.flag && !sel_q) |-> !accept_o);

    // R6: a foreign address is never delivered and leaves the station unselected
    assert_foreign_addr_R6: assert property (@(posedge clk) disable iff (rst)
        (done_i && !frame_i.ferr && frame_i.mp && frame_i.flag &&
         frame_i.data != station_id_i) |=> !sel_q);

    // R8: a bad stop bit never delivers and keeps the selection
    assert_ferr_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (done_i && frame_i.ferr) |=> (sel_q == $past(sel_q)));

endmodule

// File: rtl/mpr_status.sv
module mpr_status
    import mp_uart_rx_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 accept_i,
    input  logic [RX_DATA_W-1:0] data_i,
    input  logic                 ferr_ev_i,
    input  logic                 clr_i,
    output logic [RX_DATA_W-1:0] byte_o,
    output logic                 rdy_o,
    output logic                 ovr_o,
    output logic                 ferr_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            byte_o <= '0;
            rdy_o  <= 1'b0;
            ovr_o  <= 1'b0;
            ferr_o <= 1'b0;
        end else begin
            if (clr_i) begin
                rdy_o  <= 1'b0;
                ovr_o  <= 1'b0;
                ferr_o <= 1'b0;
            end
            if (accept_i) begin
                if (rdy_o && !clr_i) begin
                    ovr_o <= 1'b1;
                end else begin
                    byte_o <= data_i;
                    rdy_o  <= 1'b1;
                end
            end
            if (ferr_ev_i) ferr_o <= 1'b1;
        end
    end

    // R7: ready only rises on a delivery
    assert_rdy_source_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(rdy_o) |-> $past(accept_i));

    // R8: framing error flag only rises after a bad stop bit
    assert_ferr_source_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(ferr_o) |-> $past(ferr_ev_i));

    // R9: an overrun keeps the unread byte
    assert_ovr_keep_R9: assert property (@(posedge clk) disable iff (rst)
        (accept_i && rdy_o && !clr_i) |=> (ovr_o && $stable(byte_o)));

    // R10: clear drops ready unless a delivery lands in the same cycle
    assert_clr_R10: assert property (@(posedge clk) disable iff (rst)
        (clr_i && !accept_i) |=> !rdy_o);

endmodule

// File: rtl/mp_uart_rx.sv
module mp_uart_rx
    import mp_uart_rx_pkg::*;
#(
    parameter int OVS         = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       rx_i,
    input  logic       tick_i,
    input  logic [7:0] station_id_i,
    input  logic       mp_en_i,
    input  logic       flag_clr_i,
    output logic [7:0] rx_byte_o,
    output logic       rdy_o,
    output logic       overrun_o,
    output logic       frame_err_o,
    output logic       rx_irq_o,
    output logic       err_irq_o
);
    logic      done;
    rx_frame_t frame;
    logic      accept;
    logic      ferr_ev;

    mpr_sampler #(.OVS(OVS), .SYNC_STAGES(SYNC_STAGES)) u_sampler (
        .clk     (clk),
        .rst     (rst),
        .rx_i    (rx_i),
        .tick_i  (tick_i),
        .mp_en_i (mp_en_i),
        .done_o  (done),
        .frame_o (frame)
    );

    mpr_filter u_filter (
        .clk          (clk),
        .rst          (rst),
        .done_i       (done),
        .frame_i      (frame),
        .station_id_i (station_id_i),
        .accept_o     (accept),
        .ferr_ev_o    (ferr_ev)
    );

    mpr_status u_status (
        .clk       (clk),
        .rst       (rst),
        .accept_i  (accept),
        .data_i    (frame.data),
        .ferr_ev_i (ferr_ev),
        .clr_i     (flag_clr_i),
        .byte_o    (rx_byte_o),
        .rdy_o     (rdy_o),
        .ovr_o     (overrun_o),
        .ferr_o    (frame_err_o)
    );

    assign rx_irq_o  = rdy_o;
    assign err_irq_o = frame_err_o;

    // R1: nothing is flagged right after reset
    assert_reset_quiet_R1: assert property (@(posedge clk)
        $past(rst) |-> (!rdy_o && !overrun_o && !frame_err_o));

endmodule

// File: tb/sim_mp_uart_rx.sv
module sim_mp_uart_rx;
    localparam int OVS  = 16;
    localparam int TDIV = 2;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rx = 1'b1;
    logic       tick = 1'b0;
    logic [7:0] sid = 8'h5A;
    logic       mp_en = 1'b0;
    logic       clr = 1'b0;
    logic [7:0] rx_byte;
    logic       rdy, ovr, ferr, rx_irq, err_irq;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    // expected state
    logic [7:0] e_byte = 8'h00;
    bit e_rdy = 0, e_ovr = 0, e_ferr = 0, e_sel = 0;

    always #5 clk = ~clk;

    int tcnt = 0;
    always @(negedge clk) begin
        tcnt <= (tcnt == TDIV - 1) ? 0 : tcnt + 1;
        tick <= (tcnt == TDIV - 1);
    end

    mp_uart_rx u0 (
        .clk(clk), .rst(rst), .rx_i(rx), .tick_i(tick),
        .station_id_i(sid), .mp_en_i(mp_en), .flag_clr_i(clr),
        .rx_byte_o(rx_byte), .rdy_o(rdy), .overrun_o(ovr),
        .frame_err_o(ferr), .rx_irq_o(rx_irq), .err_irq_o(err_irq)
    );

    task automatic chk(input string tag, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic check_all(input string tag);
        chk(tag, "rdy", rdy, e_rdy);
        chk(tag, "byte", rx_byte, e_byte);
        chk(tag, "overrun", ovr, e_ovr);
        chk(tag, "frame_err", ferr, e_ferr);
        chk(tag, "rx_irq", rx_irq, e_rdy);
        chk(tag, "err_irq", err_irq, e_ferr);
    endtask

    task automatic send_bit(input logic v);
        rx = v;
        repeat (OVS * TDIV) @(negedge clk);
    endtask

    // expected effect of one frame
    task automatic model(input logic [7:0] d, input logic flag, input logic stopv);
        bit acc;
        if (!stopv) begin
            e_ferr = 1;
            return;
        end
        if (!mp_en) acc = 1;
        else if (flag) begin
            acc   = (d == sid);
            e_sel = (d == sid);
        end else acc = e_sel;
        if (acc) begin
            if (e_rdy) e_ovr = 1;
            else begin
                e_byte = d;
                e_rdy  = 1;
            end
        end
    endtask

    task automatic send_frame(input logic [7:0] d, input logic flag, input logic stopv,
                              input string tag);
        send_bit(1'b0);
        for (int i = 0; i < 8; i++) send_bit(d[i]);
        if (mp_en) send_bit(flag);
        send_bit(stopv);
        send_bit(1'b1);
        model(d, flag, stopv);
        check_all(tag);
    endtask

    task automatic do_clear(input string tag);
        @(negedge clk);
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
        @(negedge clk);
        e_rdy = 0; e_ovr = 0; e_ferr = 0;
        check_all(tag);
    endtask

    initial begin
        int pick;
        logic [7:0] d;
        void'($urandom(32'd1234));
        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        check_all("R1");

        // plain mode, LSB-first byte delivery
        send_frame(8'hA5, 1'b0, 1'b1, "R2");
        chk("R7", "irq follows ready", rx_irq, 1);
        do_clear("R10");
        send_frame(8'h01, 1'b0, 1'b1, "R2");
        do_clear("R10");

        // short low glitch must not start a frame
        rx = 1'b0;
        repeat (3 * TDIV) @(negedge clk);
        rx = 1'b1;
        repeat (3 * OVS * TDIV) @(negedge clk);
        check_all("R3");

        // overrun keeps first byte
        send_frame(8'h3C, 1'b0, 1'b1, "R7");
        send_frame(8'hC3, 1'b0, 1'b1, "R9");
        do_clear("R10");

        // addressed mode
        mp_en = 1'b1;
        send_frame(8'h11, 1'b0, 1'b1, "R4");
        send_frame(8'h5B, 1'b1, 1'b1, "R6");
        send_frame(8'h22, 1'b0, 1'b1, "R4");
        send_frame(8'h5A, 1'b1, 1'b1, "R5");
        do_clear("R10");
        send_frame(8'h77, 1'b0, 1'b1, "R5");
        do_clear("R10");
        send_frame(8'h66, 1'b0, 1'b0, "R8");
        do_clear("R10");
        send_frame(8'h88, 1'b0, 1'b1, "R8");
        do_clear("R10");
        send_frame(8'h00, 1'b1, 1'b1, "R6");
        send_frame(8'h99, 1'b0, 1'b1, "R6");

        // random mix
        for (int n = 0; n < 110; n++) begin
            if (n % 20 == 0) begin
                mp_en = ($urandom % 4) != 0;
                if (!mp_en) e_sel = e_sel;
            end
            if ($urandom % 2) do_clear("R10");
            pick = $urandom % 4;
            d = $urandom;
            if (pick == 0) d = sid;
            else if (pick == 1) d = sid ^ 8'h01;
            send_frame(d, ($urandom % 3) == 0, ($urandom % 10) != 0,
                       mp_en ? "R5" : "R2");
        end

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        finished = 1;
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule